// File: doc/BRIEF.md
# Memory Write ECC Fault Injector

This block sits on the write path of a memory controller, after the ECC encoder and just before the codeword is sent to the memory devices. It lets software check the error-reporting path of the read side. Software picks a target location by programming match values for six decoded address fields. Any field can be set to accept every value. Software then chooses which codeword bits to invert, which half of the data word they go into, and whether the check byte and the outgoing parity bit are corrupted as well. Finally it arms the unit. Each write carries its decoded address (DIMM, rank, channel, bank, page, column) and a 72-bit codeword. The codeword is 64 data bits in [63:0] and 8 check bits in [71:64].

A matching write is corrupted while the unit is armed, and the result appears on the output in the same cycle. In one-shot mode the unit disarms itself after the first corrupted write. In repeat mode it corrupts every matching write until software clears the arm register. Every other write leaves the block untouched and without delay. All settings can be read back through the register port. The read data is combinational from the register address.

Top module: `ecc_fault_injector`

## Requirements
- R1: After reset the unit is disarmed, all six field wildcards read back as 1 (register 5 reads 0x3F), and the type, section, data-mask and check-mask registers read 0.
- R2: Register map (4-bit address): 0 arm (bit 0), 1 type (bits 2:0), 2 section (bits 1:0), 3 data mask (32 bits), 4 check mask (8 bits), 5 wildcard (bit i for field i), 8+i match value for field i. Fields are ordered 0 DIMM, 1 rank, 2 channel, 3 bank, 4 page, 5 column. Every register reads back what was written, truncated to its width (page 16 bits, column 10, bank 3, others 2).
- R3: Writing any nonzero value to register 0 arms the unit, and writing zero disarms it. A write is corrupted only when it is valid, the unit is armed and the address matches. `inj_fired` is high in exactly that cycle.
- R4: With type bit 0 clear, the unit disarms at the clock edge that ends the first corrupted write. With type bit 0 set, it stays armed and corrupts every later matching write until register 0 is written with zero.
- R5: A field matches when its wildcard bit is 1, or when its input equals the programmed match value. A write matches only when all six fields match.
- R6: On a corrupted write, section bit 0 XORs the data mask into data bits [31:0], and section bit 1 XORs it into bits [63:32]. Section 1 selects the low half, 2 the high half, 3 both, and 0 neither.
- R7: On a corrupted write with type bit 1 set, the check-mask register is XORed into bits [71:64]. Otherwise bits [71:64] pass unchanged.
- R8: `out_parity` is the XOR of all 72 output bits. On a corrupted write with type bit 2 set, it is inverted.
- R9: When a write is not corrupted, `out_data` equals `wr_data` in the same cycle, and `out_valid` follows `wr_valid` with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| wr_valid | input | 1 | A memory write is present |
| wr_dimm | input | DIMM_W | Decoded DIMM index |
| wr_rank | input | RANK_W | Decoded rank |
| wr_chan | input | CHAN_W | Decoded channel |
| wr_bank | input | BANK_W | Decoded bank |
| wr_page | input | PAGE_W | Decoded page (row) |
| wr_col | input | COL_W | Decoded column |
| wr_data | input | DATA_W+CHK_W | Encoded codeword from the ECC encoder |
| out_valid | output | 1 | Write present on the memory side |
| out_data | output | DATA_W+CHK_W | Codeword, possibly corrupted |
| out_parity | output | 1 | Parity of out_data, possibly inverted |
| inj_fired | output | 1 | This write is being corrupted |

## Verification
Most internal state faults become visible at the next matching write. If the arm flag is stuck, or fails to clear after a one-shot, the wrong codeword appears on `out_data` in that same cycle. A comparison with a wrong field or a wildcard that is ignored makes a targeted or a non-targeted write come out with the wrong corruption. Faults in the stored settings also appear on `cfg_rdata` as soon as the register is addressed, with no clock edge in between.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
   localparam int NUM_FLD = 6;

   // register addresses
   localparam logic [3:0] A_ARM    = 4'd0;
   localparam logic [3:0] A_TYPE   = 4'd1;
   localparam logic [3:0] A_SECT   = 4'd2;
   localparam logic [3:0] A_DMASK  = 4'd3;
   localparam logic [3:0] A_CMASK  = 4'd4;
   localparam logic [3:0] A_WILD   = 4'd5;
   localparam logic [3:0] A_MATCH0 = 4'd8;

   // injection kind, bit 0 = repeat
   typedef struct packed {
      logic par;
      logic chk;
      logic rpt;
   } inj_kind_t;
endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
   import ecc_inj_pkg::*;
#(
   parameter int HALF_W = 32,
   parameter int CHK_W  = 8,
   parameter int MAXW   = 16,
   parameter int FW [NUM_FLD] = '{2, 2, 2, 3, 16, 10}
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [3:0]                    cfg_addr,
   input  logic [31:0]                   cfg_wdata,
   output logic [31:0]                   cfg_rdata,
   input  logic                          fire,
   output logic                          armed,
   output inj_kind_t                     kind,
   output logic [1:0]                    sect,
   output logic [HALF_W-1:0]             dmask,
   output logic [CHK_W-1:0]              cmask,
   output logic [NUM_FLD-1:0]            wild,
   output logic [NUM_FLD-1:0][MAXW-1:0]  mval
);
   function automatic logic [MAXW-1:0] fmask(int idx);
      logic [MAXW-1:0] m;
      m = '0;
      for (int b = 0; b < MAXW; b++) if (b < FW[idx]) m[b] = 1'b1;
      return m;
   endfunction

   if (MAXW > 32) begin : g_bad_maxw
      $error("ecc_inj_regs: MAXW must not exceed 32");
   end
   if (HALF_W > 32 || CHK_W > 32) begin : g_bad_mask
      $error("ecc_inj_regs: mask widths must not exceed 32");
   end
   for (genvar g = 0; g < NUM_FLD; g++) begin : g_fw_chk
      if (FW[g] > MAXW || FW[g] < 1) begin : g_bad
         $error("ecc_inj_regs: field width out of range");
      end
   end

   wire arm_wr = cfg_we && (cfg_addr == A_ARM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else if (arm_wr) armed <= |cfg_wdata;
      else if (fire && !kind.rpt) armed <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind  <= '0;
         sect  <= '0;
         dmask <= '0;
         cmask <= '0;
         wild  <= '1;
         mval  <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            A_TYPE:  kind  <= inj_kind_t'(cfg_wdata[2:0]);
            A_SECT:  sect  <= cfg_wdata[1:0];
            A_DMASK: dmask <= cfg_wdata[HALF_W-1:0];
            A_CMASK: cmask <= cfg_wdata[CHK_W-1:0];
            A_WILD:  wild  <= cfg_wdata[NUM_FLD-1:0];
            default: ;
         endcase
         for (int i = 0; i < NUM_FLD; i++)
            if (cfg_addr == 4'(int'(A_MATCH0) + i))
               mval[i] <= cfg_wdata[MAXW-1:0] & fmask(i);
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         A_ARM:   cfg_rdata[0]          = armed;
         A_TYPE:  cfg_rdata[2:0]        = kind;
         A_SECT:  cfg_rdata[1:0]        = sect;
         A_DMASK: cfg_rdata[HALF_W-1:0] = dmask;
         A_CMASK: cfg_rdata[CHK_W-1:0]  = cmask;
         A_WILD:  cfg_rdata[NUM_FLD-1:0] = wild;
         default: ;
      endcase
      for (int i = 0; i < NUM_FLD; i++)
         if (cfg_addr == 4'(int'(A_MATCH0) + i)) cfg_rdata[MAXW-1:0] = mval[i];
   end

   AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !kind.rpt && !arm_wr) |=> !armed); // R4
   AST_REPEAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && kind.rpt && !cfg_we) |=> armed); // R4
endmodule

// File: rtl/ecc_inj_match.sv
module ecc_inj_match
   import ecc_inj_pkg::*;
#(
   parameter int MAXW = 16
) (
   input  logic [NUM_FLD-1:0][MAXW-1:0] fld,
   input  logic [NUM_FLD-1:0][MAXW-1:0] mval,
   input  logic [NUM_FLD-1:0]           wild,
   output logic                         hit
);
   logic [NUM_FLD-1:0] fld_hit;

   for (genvar g = 0; g < NUM_FLD; g++) begin : g_cmp
      assign fld_hit[g] = wild[g] || (fld[g] == mval[g]);
   end

   assign hit = &fld_hit;
endmodule

// File: rtl/ecc_inj_flip.sv
module ecc_inj_flip
   import ecc_inj_pkg::*;
#(
   parameter int HALF_W = 32,
   parameter int CHK_W  = 8,
   localparam int CW    = 2*HALF_W + CHK_W
) (
   input  logic              fire,
   input  inj_kind_t         kind,
   input  logic [1:0]        sect,
   input  logic [HALF_W-1:0] dmask,
   input  logic [CHK_W-1:0]  cmask,
   input  logic [CW-1:0]     din,
   output logic [CW-1:0]     dout,
   output logic              parity
);
   for (genvar h = 0; h < 2; h++) begin : g_half
      assign dout[h*HALF_W +: HALF_W] =
         din[h*HALF_W +: HALF_W] ^ ((fire && sect[h]) ? dmask : '0);
   end

   assign dout[CW-1 -: CHK_W] = din[CW-1 -: CHK_W] ^ ((fire && kind.chk) ? cmask : '0);
   assign parity = (^dout) ^ (fire && kind.par);
endmodule

// File: rtl/ecc_fault_injector.sv
module ecc_fault_injector
   import ecc_inj_pkg::*;
#(
   parameter int DIMM_W = 2,
   parameter int RANK_W = 2,
   parameter int CHAN_W = 2,
   parameter int BANK_W = 3,
   parameter int PAGE_W = 16,
   parameter int COL_W  = 10,
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [3:0]              cfg_addr,
   input  logic [31:0]             cfg_wdata,
   output logic [31:0]             cfg_rdata,
   input  logic                    wr_valid,
   input  logic [DIMM_W-1:0]       wr_dimm,
   input  logic [RANK_W-1:0]       wr_rank,
   input  logic [CHAN_W-1:0]       wr_chan,
   input  logic [BANK_W-1:0]       wr_bank,
   input  logic [PAGE_W-1:0]       wr_page,
   input  logic [COL_W-1:0]        wr_col,
   input  logic [DATA_W+CHK_W-1:0] wr_data,
   output logic                    out_valid,
   output logic [DATA_W+CHK_W-1:0] out_data,
   output logic                    out_parity,
   output logic                    inj_fired
);
   localparam int HALF_W = DATA_W / 2;
   localparam int CW     = DATA_W + CHK_W;
   localparam int FW [NUM_FLD] = '{DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W};

   function automatic int widest();
      int m;
      m = 1;
      for (int i = 0; i < NUM_FLD; i++) if (FW[i] > m) m = FW[i];
      return m;
   endfunction
   localparam int MAXW = widest();

   if (DATA_W % 2 != 0) begin : g_bad_data
      $error("ecc_fault_injector: DATA_W must be even");
   end

   logic                         armed, hit, fire;
   inj_kind_t                    kind;
   logic [1:0]                   sect;
   logic [HALF_W-1:0]            dmask;
   logic [CHK_W-1:0]             cmask;
   logic [NUM_FLD-1:0]           wild;
   logic [NUM_FLD-1:0][MAXW-1:0] mval;
   logic [NUM_FLD-1:0][MAXW-1:0] fld;

   always_comb begin
      fld = '0;
      fld[0][DIMM_W-1:0] = wr_dimm;
      fld[1][RANK_W-1:0] = wr_rank;
      fld[2][CHAN_W-1:0] = wr_chan;
      fld[3][BANK_W-1:0] = wr_bank;
      fld[4][PAGE_W-1:0] = wr_page;
      fld[5][COL_W-1:0]  = wr_col;
   end

   ecc_inj_regs #(.HALF_W(HALF_W), .CHK_W(CHK_W), .MAXW(MAXW), .FW(FW)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fire(fire),
      .armed(armed), .kind(kind), .sect(sect), .dmask(dmask), .cmask(cmask),
      .wild(wild), .mval(mval)
   );

   ecc_inj_match #(.MAXW(MAXW)) u_match (
      .fld(fld), .mval(mval), .wild(wild), .hit(hit)
   );

   assign fire = wr_valid && armed && hit;

   ecc_inj_flip #(.HALF_W(HALF_W), .CHK_W(CHK_W)) u_flip (
      .fire(fire), .kind(kind), .sect(sect), .dmask(dmask), .cmask(cmask),
      .din(wr_data), .dout(out_data), .parity(out_parity)
   );

   assign out_valid = wr_valid;
   assign inj_fired = fire;

   AST_PASS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_fired |-> (out_data == wr_data)); // R9
   AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      inj_fired |-> (armed && wr_valid)); // R3
   AST_CHK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(inj_fired && kind.chk) |-> (out_data[CW-1 -: CHK_W] == wr_data[CW-1 -: CHK_W])); // R7
endmodule

// File: tb/sim_ecc_fault_injector.sv
module sim_ecc_fault_injector;
   localparam int CLK_T = 10;

   typedef struct {
      logic [71:0] data;
      logic        par;
      logic        fired;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_dimm = '0, wr_rank = '0, wr_chan = '0;
   logic [2:0]  wr_bank = '0;
   logic [15:0] wr_page = '0;
   logic [9:0]  wr_col = '0;
   logic [71:0] wr_data = '0;
   logic        out_valid, out_parity, inj_fired;
   logic [71:0] out_data;

   int checks = 0;
   int fails  = 0;
   exp_t q[$];

   // bench model of configuration
   logic        m_armed = 1'b0;
   logic [2:0]  m_type  = '0;
   logic [1:0]  m_sect  = '0;
   logic [31:0] m_dmask = '0;
   logic [7:0]  m_cmask = '0;
   logic [5:0]  m_wild  = 6'h3F;
   int          m_match [6] = '{0, 0, 0, 0, 0, 0};

   always #(CLK_T/2) clk = ~clk;

   ecc_fault_injector u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wr_valid(wr_valid),
      .wr_dimm(wr_dimm), .wr_rank(wr_rank), .wr_chan(wr_chan),
      .wr_bank(wr_bank), .wr_page(wr_page), .wr_col(wr_col),
      .wr_data(wr_data), .out_valid(out_valid), .out_data(out_data),
      .out_parity(out_parity), .inj_fired(inj_fired)
   );

   task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (a)
         4'd0: m_armed = |d;
         4'd1: m_type  = d[2:0];
         4'd2: m_sect  = d[1:0];
         4'd3: m_dmask = d;
         4'd4: m_cmask = d[7:0];
         4'd5: m_wild  = d[5:0];
         4'd8: m_match[0] = int'(d[1:0]);
         4'd9: m_match[1] = int'(d[1:0]);
         4'd10: m_match[2] = int'(d[1:0]);
         4'd11: m_match[3] = int'(d[2:0]);
         4'd12: m_match[4] = int'(d[15:0]);
         4'd13: m_match[5] = int'(d[9:0]);
         default: ;
      endcase
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      cfg_addr = a;
      #1;
      checks++;
      if (cfg_rdata !== exp) begin
         fails++;
         $display("FAIL %s: reg %0d read %h expected %h", tag, a, cfg_rdata, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] d, input logic [1:0] r, input logic [1:0] c,
                           input logic [2:0] b, input logic [15:0] p, input logic [9:0] col,
                           input logic [71:0] dat, input string tag);
      exp_t e;
      logic hit, fire;
      int   fv [6];
      fv = '{int'(d), int'(r), int'(c), int'(b), int'(p), int'(col)};
      hit = 1'b1;
      for (int i = 0; i < 6; i++) if (!m_wild[i] && fv[i] != m_match[i]) hit = 1'b0;
      fire = m_armed && hit;
      e.data = dat;
      if (fire && m_sect[0]) e.data[31:0]  = e.data[31:0]  ^ m_dmask;
      if (fire && m_sect[1]) e.data[63:32] = e.data[63:32] ^ m_dmask;
      if (fire && m_type[1]) e.data[71:64] = e.data[71:64] ^ m_cmask;
      e.par   = (^e.data) ^ (fire && m_type[2]);
      e.fired = fire;
      e.tag   = tag;
      if (fire && !m_type[0]) m_armed = 1'b0;
      @(negedge clk);
      wr_valid = 1'b1; wr_dimm = d; wr_rank = r; wr_chan = c;
      wr_bank = b; wr_page = p; wr_col = col; wr_data = dat;
      q.push_back(e);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_T/4);
         if (out_valid === 1'b1) begin
            checks++;
            if (q.size() == 0) begin
               fails++;
               $display("FAIL R9: output with no expected item, data %h expected none", out_data);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (out_data !== e.data || out_parity !== e.par || inj_fired !== e.fired) begin
                  fails++;
                  $display("FAIL %s: data %h par %b fired %b expected data %h par %b fired %b",
                           e.tag, out_data, out_parity, inj_fired, e.data, e.par, e.fired);
               end
            end
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_T * 20000);
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   localparam logic [71:0] D0 = 72'hA5_0123_4567_89AB_CDEF;
   localparam logic [71:0] D1 = 72'h3C_FEDC_BA98_7654_3210;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd_chk(4'd5, 32'h3F, "R1 wildcards");
      rd_chk(4'd0, 32'h0,  "R1 armed");
      rd_chk(4'd1, 32'h0,  "R1 type");
      rd_chk(4'd3, 32'h0,  "R1 dmask");

      // R3/R9: disarmed write passes unchanged
      do_write(2'd1, 2'd0, 2'd1, 3'd2, 16'h0010, 10'h005, D0, "R3 R9 disarmed pass");

      // R2: register programming and readback
      cfg_wr(4'd3, 32'h0000_0001);
      cfg_wr(4'd4, 32'h0000_0081);
      cfg_wr(4'd2, 32'h1);
      cfg_wr(4'd1, 32'h0);
      cfg_wr(4'd0, 32'h5);
      rd_chk(4'd0, 32'h1,  "R3 nonzero arms");
      rd_chk(4'd3, 32'h1,  "R2 dmask");
      rd_chk(4'd4, 32'h81, "R2 cmask");
      rd_chk(4'd2, 32'h1,  "R2 sect");

      // R4 one-shot, R6 low half only, R7 check untouched
      do_write(2'd0, 2'd0, 2'd0, 3'd0, 16'h0000, 10'h000, D0, "R4 R6 one-shot low half");
      do_write(2'd0, 2'd0, 2'd0, 3'd0, 16'h0000, 10'h000, D1, "R4 one-shot disarmed");
      rd_chk(4'd0, 32'h0, "R4 auto disarm");

      // R4 repeat, R6 both halves, R7 check byte
      cfg_wr(4'd1, 32'h3);
      cfg_wr(4'd2, 32'h3);
      cfg_wr(4'd3, 32'hF0F0_0FF0);
      cfg_wr(4'd0, 32'h1);
      do_write(2'd2, 2'd1, 2'd0, 3'd4, 16'h0400, 10'h3FF, D0, "R4 R6 R7 repeat first");
      do_write(2'd3, 2'd2, 2'd1, 3'd1, 16'h0800, 10'h001, D1, "R4 R7 repeat second");
      rd_chk(4'd0, 32'h1, "R4 stays armed");
      cfg_wr(4'd0, 32'h0);
      do_write(2'd2, 2'd1, 2'd0, 3'd4, 16'h0400, 10'h3FF, D0, "R3 zero disarms");

      // R5: field matching with wildcards; R6 high half only
      cfg_wr(4'd1, 32'h1);
      cfg_wr(4'd2, 32'h2);
      cfg_wr(4'd8, 32'h1);
      cfg_wr(4'd11, 32'h5);
      cfg_wr(4'd12, 32'h1234);
      cfg_wr(4'd13, 32'h2A);
      cfg_wr(4'd5, 32'h06);
      cfg_wr(4'd0, 32'h1);
      do_write(2'd1, 2'd3, 2'd2, 3'd5, 16'h1234, 10'h02A, D0, "R5 R6 exact match high half");
      do_write(2'd1, 2'd0, 2'd0, 3'd5, 16'h1234, 10'h02A, D1, "R5 wildcard rank chan");
      do_write(2'd1, 2'd0, 2'd0, 3'd5, 16'h1235, 10'h02A, D0, "R5 page mismatch");
      do_write(2'd0, 2'd0, 2'd0, 3'd5, 16'h1234, 10'h02A, D0, "R5 dimm mismatch");
      do_write(2'd1, 2'd0, 2'd0, 3'd5, 16'h1234, 10'h02B, D1, "R5 column mismatch");

      // R8: parity corruption, section 0 leaves data alone
      cfg_wr(4'd1, 32'h5);
      cfg_wr(4'd2, 32'h0);
      do_write(2'd1, 2'd1, 2'd1, 3'd5, 16'h1234, 10'h02A, D1, "R8 R6 parity only");
      do_write(2'd1, 2'd1, 2'd1, 3'd6, 16'h1234, 10'h02A, D1, "R8 parity on pass");

      // R2: truncation to field width
      cfg_wr(4'd12, 32'h000A_BCDE);
      rd_chk(4'd12, 32'h0000_BCDE, "R2 page truncate");
      cfg_wr(4'd11, 32'hFF);
      rd_chk(4'd11, 32'h7, "R2 bank truncate");
      rd_chk(4'd5, 32'h06, "R2 wildcard readback");

      repeat (4) @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL R9: %0d expected items left, expected 0", q.size());
      end
      finish_run();
   end
endmodule